// File: doc/BRIEF.md
# Programmable Sync Edge Detector

This block takes the horizontal and vertical sync pins of a video overlay controller into the dot-clock domain and turns them into two one-cycle timing pulses: `line_start`, which marks the horizontal edge chosen to drive line operation, and `field_start`, which marks a detected vertical sync. Both sync pins go through two-flop synchronizers. An input-polarity setting then decides whether a high or a low pin level counts as active. Three edge-select settings decide which horizontal edge drives line operation, which vertical edge counts as a field boundary, and at which horizontal edge the vertical level is sampled. One of the sampling points is placed a fixed number of dot clocks after the horizontal leading edge.

The block also gates the layer enables (main text, sprite, screen background). A layer that is switched on stays dark until the next detected field boundary, so that it always starts drawing at the top of a field. A layer that is switched off goes dark at once. The colour code and the blanking outputs pass through a registered stage with its own inversion setting for each group.

The configuration is loaded as one word when `cfg_we` is high and is cleared by reset. The block carries no data stream, so every pin is a plain level or a pulse, with no valid/ready handshake and no back-pressure.

Top module: `osd_sync_qualifier`

## Requirements
- R1: After reset every configuration bit is 0. The sync pins are treated as active-low, line operation uses the horizontal trailing edge, vertical sampling uses the horizontal leading edge, and the vertical leading edge is detected. Also after reset, no pulse is produced, `layer_en` is 000, and the colour and blanking outputs equal their raw inputs one cycle later.
- R2: Each sync pin passes through two synchronizer flops. A `line_start` pulse is exactly one cycle wide and is high in the third cycle after the first clock edge that sees the pin change.
- R3: With `cfg_sync_pos`=1 a high pin level is active; with 0 a low pin level is active. The setting applies to both sync pins.
- R4: With `cfg_hop_lead`=0, `line_start` follows the horizontal trailing edge (active to inactive). With 1 it follows the leading edge (inactive to active).
- R5: With `cfg_vref_trail`=0, the vertical level is sampled at the horizontal leading edge, whatever the other two selects are.
- R6: With `cfg_vref_trail`=1, the vertical level is sampled at the horizontal trailing edge when `cfg_hop_lead`=0, and also when `cfg_hop_lead`=1 and `cfg_vs_trail`=0.
- R7: With `cfg_vs_trail`, `cfg_vref_trail` and `cfg_hop_lead` all 1, the vertical level is sampled 10 dot clocks after the internal horizontal leading-edge event. `field_start` is then high 13 cycles after the drive cycle of the horizontal pin.
- R8: `field_start` is a one-cycle pulse. It is produced at a sampling point where the sampled vertical level goes inactive to active (`cfg_vs_trail`=0) or active to inactive (`cfg_vs_trail`=1), compared with the previous sampling point. It is registered one cycle after that sampling point.
- R9: A `layer_req` bit that turns on does not raise its `layer_en` bit before the next `field_start`. `layer_en` rises in the same cycle as that `field_start`. Bit 0 is main text, bit 1 is sprite, bit 2 is screen background.
- R10: Clearing a `layer_req` bit clears the matching `layer_en` bit in the same cycle, with no wait for vertical sync.
- R11: `col_out` is `col_raw` registered one cycle, inverted when `cfg_col_neg`=1. `blk_out` is `blk_raw` registered one cycle, inverted when `cfg_blk_neg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all configuration bits this cycle |
| cfg_sync_pos | input | 1 | Sync pins active-high (1) or active-low (0) |
| cfg_vs_trail | input | 1 | Detect vertical trailing (1) or leading (0) edge |
| cfg_vref_trail | input | 1 | Horizontal edge select for vertical sampling |
| cfg_hop_lead | input | 1 | Line operation on horizontal leading (1) or trailing (0) edge |
| cfg_col_neg | input | 1 | Invert colour code output |
| cfg_blk_neg | input | 1 | Invert blanking outputs |
| hs_pin | input | 1 | Horizontal sync pin, asynchronous |
| vs_pin | input | 1 | Vertical sync pin, asynchronous |
| layer_req | input | 3 | Requested layer enables (main, sprite, background) |
| col_raw | input | 4 | Colour code from the pixel path |
| blk_raw | input | 3 | Blanking/display-period signals from the pixel path |
| line_start | output | 1 | One-cycle line timing pulse |
| field_start | output | 1 | One-cycle field timing pulse |
| layer_en | output | 3 | Effective layer enables |
| col_out | output | 4 | Colour code after polarity stage |
| blk_out | output | 3 | Blanking signals after polarity stage |

## Verification
Two functions can land in the same cycle: `line_start` and `field_start`. They coincide whenever the horizontal edge that drives line operation is also the vertical sampling point, and a pending layer enable rises in that same cycle. The bench provokes this by driving the vertical pin active before a horizontal pulse with leading-edge line operation and leading-edge sampling, and with the trailing-edge pair. A scoreboard holds the expected pulse cycles, which the bench computes from the selection table. Both pulses must match their queued cycle numbers, and the `layer_en` value captured in the `field_start` cycle must already show the requested layers.

// File: rtl/osq_pkg.sv
package osq_pkg;

  typedef enum logic [1:0] {
    REF_H_LEAD    = 2'd0,
    REF_H_TRAIL   = 2'd1,
    REF_H_DELAYED = 2'd2
  } vref_src_e;

  typedef struct packed {
    logic sync_pos;
    logic vs_trail;
    logic vref_trail;
    logic hop_lead;
    logic col_neg;
    logic blk_neg;
  } osq_cfg_t;

  // Sampling point of the vertical level, chosen by the three edge selects.
  function automatic vref_src_e pick_vref(logic vs_trail, logic vref_trail, logic hop_lead);
    if (!vref_trail)    return REF_H_LEAD;
    else if (!hop_lead) return REF_H_TRAIL;
    else if (!vs_trail) return REF_H_TRAIL;
    else                return REF_H_DELAYED;
  endfunction

endpackage

// File: rtl/osq_sync_level.sv
module osq_sync_level #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic raw
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], pin};
  end

  assign raw = sh[STAGES-1];
endmodule

// File: rtl/osq_edge_det.sv
module osq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pos,
  input  logic warm,
  output logic lead,
  output logic trail
);
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= raw;
  end

  // Edges are found on the raw level, so a polarity change makes no false edge.
  assign rise  = raw & ~prev;
  assign fall  = ~raw & prev;
  assign lead  = warm & (pos ? rise : fall);
  assign trail = warm & (pos ? fall : rise);
endmodule

// File: rtl/osq_vref.sv
module osq_vref
  import osq_pkg::*;
#(
  parameter int DELAY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_trail,
  input  logic vref_trail,
  input  logic hop_lead,
  input  logic h_lead,
  input  logic h_trail,
  input  logic v_act,
  output logic field_evt
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          samp;
  logic          h_dly;
  logic          ref_hit;
  vref_src_e     src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (h_lead)      cnt <= CW'(DELAY);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign h_dly = (cnt == CW'(1));
  assign src   = pick_vref(vs_trail, vref_trail, hop_lead);

  always_comb begin
    unique case (src)
      REF_H_LEAD:    ref_hit = h_lead;
      REF_H_TRAIL:   ref_hit = h_trail;
      REF_H_DELAYED: ref_hit = h_dly;
      default:       ref_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp <= 1'b0;
    else if (ref_hit) samp <= v_act;
  end

  assign field_evt = ref_hit & (vs_trail ? (samp & ~v_act) : (~samp & v_act));

  // R7: the delay counter never runs past its load value
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DELAY));
endmodule

// File: rtl/osq_layer_gate.sv
module osq_layer_gate #(
  parameter int NL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] req,
  input  logic          field_evt,
  output logic [NL-1:0] en
);
  logic [NL-1:0] armed;

  for (genvar i = 0; i < NL; i++) begin : g_layer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed[i] <= 1'b0;
      else if (!req[i])   armed[i] <= 1'b0;
      else if (field_evt) armed[i] <= 1'b1;
    end
    assign en[i] = req[i] & armed[i];

    // R9: a layer only turns on right after a field event
    a_r9_on_at_field: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en[i]) |-> $past(field_evt));
  end
endmodule

// File: rtl/osq_out_pol.sv
module osq_out_pol #(
  parameter int CW = 4,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_neg,
  input  logic          blk_neg,
  input  logic [CW-1:0] col_raw,
  input  logic [BW-1:0] blk_raw,
  output logic [CW-1:0] col_out,
  output logic [BW-1:0] blk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_out <= '0;
      blk_out <= '0;
    end else begin
      col_out <= col_raw ^ {CW{col_neg}};
      blk_out <= blk_raw ^ {BW{blk_neg}};
    end
  end

  // R11: steady inputs give a steady colour output
  a_r11_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(col_raw) && $stable(col_neg)) |=> $stable(col_out));
endmodule

// File: rtl/osd_sync_qualifier.sv
module osd_sync_qualifier
  import osq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VREF_DELAY  = 10,
  parameter int NUM_LAYERS  = 3,
  parameter int COL_W       = 4,
  parameter int BLK_W       = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sync_pos,
  input  logic                  cfg_vs_trail,
  input  logic                  cfg_vref_trail,
  input  logic                  cfg_hop_lead,
  input  logic                  cfg_col_neg,
  input  logic                  cfg_blk_neg,
  input  logic                  hs_pin,
  input  logic                  vs_pin,
  input  logic [NUM_LAYERS-1:0] layer_req,
  input  logic [COL_W-1:0]      col_raw,
  input  logic [BLK_W-1:0]      blk_raw,
  output logic                  line_start,
  output logic                  field_start,
  output logic [NUM_LAYERS-1:0] layer_en,
  output logic [COL_W-1:0]      col_out,
  output logic [BLK_W-1:0]      blk_out
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  osq_cfg_t          cfg_q;
  logic [WARM_W-1:0] warm_cnt;
  logic              warm;
  logic              h_raw, v_raw, v_act;
  logic              h_lead, h_trail;
  logic              field_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) begin
      cfg_q.sync_pos   <= cfg_sync_pos;
      cfg_q.vs_trail   <= cfg_vs_trail;
      cfg_q.vref_trail <= cfg_vref_trail;
      cfg_q.hop_lead   <= cfg_hop_lead;
      cfg_q.col_neg    <= cfg_col_neg;
      cfg_q.blk_neg    <= cfg_blk_neg;
    end
  end

  // Edges stay masked until the synchronizer holds real pin samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       warm_cnt <= '0;
    else if (warm_cnt != WARM_W'(WARM)) warm_cnt <= warm_cnt + WARM_W'(1);
  end
  assign warm = (warm_cnt == WARM_W'(WARM));

  osq_sync_level #(.STAGES(SYNC_STAGES)) u_hs_sync (
    .clk(clk), .rst_n(rst_n), .pin(hs_pin), .raw(h_raw));

  osq_sync_level #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .pin(vs_pin), .raw(v_raw));

  assign v_act = cfg_q.sync_pos ? v_raw : ~v_raw;

  osq_edge_det u_hs_edge (
    .clk(clk), .rst_n(rst_n), .raw(h_raw), .pos(cfg_q.sync_pos),
    .warm(warm), .lead(h_lead), .trail(h_trail));

  osq_vref #(.DELAY(VREF_DELAY)) u_vref (
    .clk(clk), .rst_n(rst_n),
    .vs_trail(cfg_q.vs_trail), .vref_trail(cfg_q.vref_trail),
    .hop_lead(cfg_q.hop_lead), .h_lead(h_lead), .h_trail(h_trail),
    .v_act(v_act), .field_evt(field_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_start  <= 1'b0;
      field_start <= 1'b0;
    end else begin
      line_start  <= cfg_q.hop_lead ? h_lead : h_trail;
      field_start <= field_evt;
    end
  end

  osq_layer_gate #(.NL(NUM_LAYERS)) u_gate (
    .clk(clk), .rst_n(rst_n), .req(layer_req),
    .field_evt(field_evt), .en(layer_en));

  osq_out_pol #(.CW(COL_W), .BW(BLK_W)) u_pol (
    .clk(clk), .rst_n(rst_n),
    .col_neg(cfg_q.col_neg), .blk_neg(cfg_q.blk_neg),
    .col_raw(col_raw), .blk_raw(blk_raw),
    .col_out(col_out), .blk_out(blk_out));

  // R2: line pulses last one cycle
  a_r2_line_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R8: field pulses last one cycle
  a_r8_field_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);
endmodule

// File: tb/osd_sync_qualifier_bench.sv
module osd_sync_qualifier_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_sync_pos, cfg_vs_trail, cfg_vref_trail, cfg_hop_lead;
  logic       cfg_col_neg, cfg_blk_neg;
  logic       hs_pin, vs_pin;
  logic [2:0] layer_req;
  logic [3:0] col_raw;
  logic [2:0] blk_raw;
  logic       line_start, field_start;
  logic [2:0] layer_en;
  logic [3:0] col_out;
  logic [2:0] blk_out;

  always #2 clk = ~clk;

  osd_sync_qualifier u_osd_sync_qualifier (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sync_pos(cfg_sync_pos),
    .cfg_vs_trail(cfg_vs_trail), .cfg_vref_trail(cfg_vref_trail),
    .cfg_hop_lead(cfg_hop_lead), .cfg_col_neg(cfg_col_neg), .cfg_blk_neg(cfg_blk_neg),
    .hs_pin(hs_pin), .vs_pin(vs_pin), .layer_req(layer_req),
    .col_raw(col_raw), .blk_raw(blk_raw), .line_start(line_start),
    .field_start(field_start), .layer_en(layer_en), .col_out(col_out), .blk_out(blk_out));

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  int   q_line[$];
  int   q_field[$];
  logic [2:0] fs_en = 3'b000;
  bit   m_pos = 0, m_vt = 0, m_hvt = 0, m_hl = 0;
  bit   vs_act = 0, m_samp = 0;
  bit   done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected pulse cycles and compares.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (line_start) begin
        if (q_line.size() == 0) chk(0, "R2 unexpected line_start", cyc, -1);
        else begin
          chk(q_line[0] == cyc, "R2/R4 line_start cycle", cyc, q_line[0]);
          void'(q_line.pop_front());
        end
      end
      if (field_start) begin
        fs_en = layer_en;
        if (q_field.size() == 0) chk(0, "R8 unexpected field_start", cyc, -1);
        else begin
          chk(q_field[0] == cyc, "R5/R6/R7/R8 field_start cycle", cyc, q_field[0]);
          void'(q_field.pop_front());
        end
      end
    end
  end

  task automatic drive_idle();
    hs_pin = !m_pos;
    vs_pin = m_pos ? vs_act : !vs_act;
  endtask

  task automatic set_cfg(bit pos, bit vt, bit hvt, bit hl, bit cn, bit bn);
    @(negedge clk);
    cfg_sync_pos = pos; cfg_vs_trail = vt; cfg_vref_trail = hvt;
    cfg_hop_lead = hl; cfg_col_neg = cn; cfg_blk_neg = bn; cfg_we = 1'b1;
    m_pos = pos; m_vt = vt; m_hvt = hvt; m_hl = hl;
    drive_idle();
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_vs(bit v);
    @(negedge clk);
    vs_act = v;
    drive_idle();
    repeat (6) @(negedge clk);
  endtask

  // Driver: one horizontal pulse, with expected pulses pushed to the queues.
  task automatic hpulse(int w);
    int c0, c1, kind;
    bit vhit;
    kind = !m_hvt ? 0 : (!m_hl ? 1 : (!m_vt ? 1 : 2));
    vhit = m_vt ? (m_samp && !vs_act) : (!m_samp && vs_act);
    m_samp = vs_act;
    @(negedge clk);
    hs_pin = m_pos; c0 = cyc;
    if (m_hl) q_line.push_back(c0 + 3);
    if (vhit && kind == 0) q_field.push_back(c0 + 3);
    if (vhit && kind == 2) q_field.push_back(c0 + 13);
    repeat (w) @(negedge clk);
    hs_pin = !m_pos; c1 = cyc;
    if (!m_hl) q_line.push_back(c1 + 3);
    if (vhit && kind == 1) q_field.push_back(c1 + 3);
    repeat (18) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sync_pos = 0; cfg_vs_trail = 0; cfg_vref_trail = 0;
    cfg_hop_lead = 0; cfg_col_neg = 0; cfg_blk_neg = 0;
    layer_req = 3'b000; col_raw = 4'h3; blk_raw = 3'b010;
    drive_idle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: reset state
    chk(line_start == 0 && field_start == 0, "R1 no pulses after reset", line_start, 0);
    chk(layer_en == 3'b000, "R1 layer_en after reset", layer_en, 0);
    chk(col_out == 4'h3, "R1 col_out pass-through", col_out, 3);
    chk(blk_out == 3'b010, "R1 blk_out pass-through", blk_out, 2);

    // R4 trailing edge line operation, vertical inactive: no field
    hpulse(4);

    // R9 request before the field
    @(negedge clk); layer_req = 3'b111;
    @(negedge clk);
    chk(layer_en == 3'b000, "R9 enable waits for field", layer_en, 0);
    // R5/R8 leading reference, vertical leading edge
    set_vs(1);
    chk(layer_en == 3'b000, "R9 enable still waiting", layer_en, 0);
    hpulse(4);
    chk(fs_en == 3'b111, "R9 enable in field_start cycle", fs_en, 7);
    chk(layer_en == 3'b111, "R9 enable after field", layer_en, 7);

    // R10 turn-off is immediate
    @(negedge clk); layer_req = 3'b101; #1;
    chk(layer_en == 3'b101, "R10 immediate turn-off", layer_en, 5);
    @(negedge clk); layer_req = 3'b111; #1;
    chk(layer_en == 3'b101, "R9 re-enable waits", layer_en, 5);

    // R4 leading edge line operation
    set_cfg(0, 0, 0, 1, 0, 0);
    hpulse(5);
    set_vs(0);
    hpulse(3);

    // R8 vertical trailing edge with leading reference
    set_cfg(0, 1, 0, 0, 0, 0);
    set_vs(1);
    hpulse(4);
    set_vs(0);
    hpulse(4);
    chk(layer_en == 3'b111, "R9 re-enable after field", layer_en, 7);

    // R6 trailing reference, line on trailing edge: pulses coincide
    set_cfg(0, 0, 1, 0, 0, 0);
    set_vs(1);
    hpulse(4);

    // R6 trailing reference with line on leading edge
    set_cfg(0, 0, 1, 1, 0, 0);
    set_vs(0);
    hpulse(4);
    set_vs(1);
    hpulse(6);

    // R7 delayed reference
    set_cfg(0, 1, 1, 1, 0, 0);
    set_vs(0);
    hpulse(4);

    // R3 positive logic and R11 inversion
    set_cfg(1, 0, 0, 1, 1, 1);
    @(negedge clk); col_raw = 4'h5; blk_raw = 3'b001;
    @(negedge clk);
    chk(col_out == 4'hA, "R11 colour inverted", col_out, 10);
    chk(blk_out == 3'b110, "R11 blanking inverted", blk_out, 6);
    set_vs(1);
    hpulse(4);
    set_vs(0);
    hpulse(2);

    repeat (10) @(negedge clk);
    chk(q_line.size() == 0, "R2 missing line_start", q_line.size(), 0);
    chk(q_field.size() == 0, "R8 missing field_start", q_field.size(), 0);
    finish_run();
  end
endmodule